// File: doc/BRIEF.md
# Serial Port Byte Queues with Watermark Interrupts

This block sits between the register bus of a serial peripheral controller and its bit shifter. It holds two byte queues. The outbound queue is filled by software and drained by the shift engine. The inbound queue is filled by the shift engine and drained by software. The fill level of each queue is published in a single 32-bit level word, so a driver can work out how much to read or write before it touches the data ports.

Three interrupt sources are tracked: the inbound queue filling past three quarters, the outbound queue draining to a quarter or less, and a transfer-complete pulse from the engine. Each source has a pending bit and an enable bit, at the same position in both words. Software clears a pending bit by writing a 1 to it. A single control-word write can empty either queue, or both. Address decoding, the shifter and clock generation are outside the block: each register access arrives as its own strobe with a data word.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Each queue holds up to 64 bytes and returns them in arrival order. A pop strobe presents the byte on the queue's read port in the cycle after the strobe.
- R2: The level word carries the inbound count (0..64) in bits [6:0] and the outbound count in bits [22:16]. Every other bit reads 0.
- R3: A push to a queue holding 64 bytes is dropped. The count stays 64 and the queued bytes are unchanged.
- R4: A pop from an empty queue is dropped. The count stays 0 and the read port keeps its previous byte.
- R5: On a control write, bit 8 empties the outbound queue and bit 9 empties the inbound queue. Each leaves the other queue alone. An empty request wins over a push or pop to the same queue in the same cycle.
- R6: Pending bit 4 is set one cycle after the inbound count is 48 or more.
- R7: Pending bit 12 is set one cycle after the outbound count is 16 or less.
- R8: Pending bit 16 is set by a transfer-done pulse and holds until it is cleared.
- R9: A status write clears the pending bits written as 1, in that cycle, and leaves bits written as 0 untouched. A source whose condition still holds sets its bit again one cycle later.
- R10: The enable word stores only bits 4, 12 and 16. Every other bit reads 0.
- R11: The irq output equals the OR of the pending bits that are also enabled, in the same cycle those registers show.
- R12: While reset is held, both counts, the pending word, the enable word and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_tx_push | input | 1 | Software push strobe to the outbound queue |
| sw_tx_byte | input | 8 | Byte pushed by software |
| sw_rx_pop | input | 1 | Software pop strobe from the inbound queue |
| sw_rx_byte | output | 8 | Byte most recently popped by software |
| eng_tx_pop | input | 1 | Engine pop strobe from the outbound queue |
| eng_tx_byte | output | 8 | Byte most recently popped by the engine |
| eng_rx_push | input | 1 | Engine push strobe to the inbound queue |
| eng_rx_byte | input | 8 | Byte pushed by the engine |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 32 | Control word (bit 8 empties outbound, bit 9 empties inbound) |
| ien_wr | input | 1 | Enable-word write strobe |
| ien_wdata | input | 32 | Enable word value |
| ists_wr | input | 1 | Pending-word write-one-to-clear strobe |
| ists_wdata | input | 32 | Mask of pending bits to clear |
| xfer_done | input | 1 | Transfer-complete pulse from the engine |
| fifo_level | output | 32 | Level word of both queue counts |
| ien | output | 32 | Enable word |
| ists | output | 32 | Pending word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a strobe lasts one cycle per access and that the data word is valid whenever its strobe is high. They also assume that a clear and a new transfer-done pulse never fall in the same cycle, because the pulse would then be lost. The stimulus drives every strobe for exactly one clock, between falling edges, and drives at most one access per cycle. The only exceptions are the deliberate collisions: an empty request with a push, and pushes or pops at the full and empty limits.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned WORD_W      = 32;
  // Positions shared by the enable and pending words.
  localparam int unsigned BIT_RXWM    = 4;
  localparam int unsigned BIT_TXWM    = 12;
  localparam int unsigned BIT_DONE    = 16;
  // Control-word bits that empty a queue.
  localparam int unsigned BIT_TXFLUSH = 8;
  localparam int unsigned BIT_RXFLUSH = 9;
  // Level word field offsets.
  localparam int unsigned LVL_RX_LSB  = 0;
  localparam int unsigned LVL_TX_LSB  = 16;
  localparam logic [WORD_W-1:0] IRQ_MASK =
    (WORD_W'(1) << BIT_RXWM) | (WORD_W'(1) << BIT_TXWM) | (WORD_W'(1) << BIT_DONE);
  // Queue indices inside the top-level generate.
  localparam int unsigned Q_TX = 0;
  localparam int unsigned Q_RX = 1;
  localparam int unsigned Q_N  = 2;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push_ok, pop_ok;

  // An empty request beats traffic; limits drop the access outright.
  assign push_ok = push && !flush && (count != FULL);
  assign pop_ok  = pop  && !flush && (count != '0);

  // Storage has no reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop_ok) begin
      pop_data <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy never exceeds the depth.
  p_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
  // R3: a lone push at full leaves the count at full.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (count == FULL) && push && !pop && !flush |=> count == FULL);
  // R4: a lone pop when empty leaves the count at zero and the read port still.
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (count == '0) && pop && !push && !flush |=> (count == '0) && $stable(pop_data));
  // R5: an empty request always lands.
  p_flush_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs import spi_fifo_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic              xfer_done,
  input  logic              ien_wr,
  input  logic [WORD_W-1:0] ien_wdata,
  input  logic              ists_wr,
  input  logic [WORD_W-1:0] ists_wdata,
  output logic [WORD_W-1:0] ien,
  output logic [WORD_W-1:0] ists,
  output logic              irq
);
  localparam logic [CNT_W-1:0] RX_HI = CNT_W'((DEPTH * 3) / 4);
  localparam logic [CNT_W-1:0] TX_LO = CNT_W'(DEPTH / 4);

  logic [WORD_W-1:0] cond, clr, ists_d, ien_d;

  always_comb begin
    cond           = '0;
    cond[BIT_RXWM] = (rx_cnt >= RX_HI);
    cond[BIT_TXWM] = (tx_cnt <= TX_LO);
    cond[BIT_DONE] = xfer_done;
  end

  // Clear wins in its own cycle; a live source re-arms one cycle later.
  assign clr    = ists_wr ? (ists_wdata & IRQ_MASK) : '0;
  assign ists_d = (ists | cond) & ~clr & IRQ_MASK;
  assign ien_d  = ien_wr ? (ien_wdata & IRQ_MASK) : ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      ists <= '0;
      ien  <= '0;
      irq  <= 1'b0;
    end else begin
      ists <= ists_d;
      ien  <= ien_d;
      irq  <= |(ists_d & ien_d);
    end
  end

  p_rx_wm_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt >= RX_HI) && !(ists_wr && ists_wdata[BIT_RXWM]) |=> ists[BIT_RXWM]);
  p_tx_wm_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt <= TX_LO) && !(ists_wr && ists_wdata[BIT_TXWM]) |=> ists[BIT_TXWM]);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ists[BIT_DONE] && !(ists_wr && ists_wdata[BIT_DONE]) |=> ists[BIT_DONE]);
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    ists_wr && ists_wdata[BIT_DONE] |=> !ists[BIT_DONE]);
  p_en_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (ien & ~IRQ_MASK) == '0);
  p_irq_or_r11: assert property (@(posedge clk) disable iff (rst)
    irq == |(ists & ien));
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit import spi_fifo_pkg::*; #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_tx_push,
  input  logic [DATA_W-1:0] sw_tx_byte,
  input  logic              sw_rx_pop,
  output logic [DATA_W-1:0] sw_rx_byte,
  input  logic              eng_tx_pop,
  output logic [DATA_W-1:0] eng_tx_byte,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_byte,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              ien_wr,
  input  logic [WORD_W-1:0] ien_wdata,
  input  logic              ists_wr,
  input  logic [WORD_W-1:0] ists_wdata,
  input  logic              xfer_done,
  output logic [WORD_W-1:0] fifo_level,
  output logic [WORD_W-1:0] ien,
  output logic [WORD_W-1:0] ists,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;
  localparam logic [WORD_W-1:0] TXF_M = WORD_W'(1) << BIT_TXFLUSH;
  localparam logic [WORD_W-1:0] RXF_M = WORD_W'(1) << BIT_RXFLUSH;

  logic [Q_N-1:0]    q_flush, q_push, q_pop;
  logic [DATA_W-1:0] q_wdata [Q_N];
  logic [DATA_W-1:0] q_rdata [Q_N];
  logic [CNT_W-1:0]  q_cnt   [Q_N];

  // Steering: software feeds outbound, engine feeds inbound.
  assign q_flush[Q_TX] = ctl_wr && |(ctl_wdata & TXF_M);
  assign q_flush[Q_RX] = ctl_wr && |(ctl_wdata & RXF_M);
  assign q_push[Q_TX]  = sw_tx_push;
  assign q_push[Q_RX]  = eng_rx_push;
  assign q_pop[Q_TX]   = eng_tx_pop;
  assign q_pop[Q_RX]   = sw_rx_pop;
  assign q_wdata[Q_TX] = sw_tx_byte;
  assign q_wdata[Q_RX] = eng_rx_byte;
  assign eng_tx_byte   = q_rdata[Q_TX];
  assign sw_rx_byte    = q_rdata[Q_RX];

  for (genvar g = 0; g < Q_N; g++) begin : g_queue
    spi_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .flush     (q_flush[g]),
      .push      (q_push[g]),
      .push_data (q_wdata[g]),
      .pop       (q_pop[g]),
      .pop_data  (q_rdata[g]),
      .count     (q_cnt[g])
    );
  end

  always_comb begin
    fifo_level = '0;
    fifo_level[LVL_RX_LSB +: CNT_W] = q_cnt[Q_RX];
    fifo_level[LVL_TX_LSB +: CNT_W] = q_cnt[Q_TX];
  end

  spi_irq_regs #(.DEPTH(DEPTH)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .rx_cnt     (q_cnt[Q_RX]),
    .tx_cnt     (q_cnt[Q_TX]),
    .xfer_done  (xfer_done),
    .ien_wr     (ien_wr),
    .ien_wdata  (ien_wdata),
    .ists_wr    (ists_wr),
    .ists_wdata (ists_wdata),
    .ien        (ien),
    .ists       (ists),
    .irq        (irq)
  );

  // R2: padding around the two count fields stays zero.
  p_level_pad_r2: assert property (@(posedge clk) disable iff (rst)
    (fifo_level & ~((WORD_W'((1 << CNT_W) - 1) << LVL_RX_LSB) |
                    (WORD_W'((1 << CNT_W) - 1) << LVL_TX_LSB))) == '0);
endmodule

// File: tb/spi_fifo_irq_unit_tb.sv
module spi_fifo_irq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_tx_push = 0, sw_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic ctl_wr = 0, ien_wr = 0, ists_wr = 0, xfer_done = 0;
  logic [7:0]  sw_tx_byte = '0, eng_rx_byte = '0;
  logic [31:0] ctl_wdata = '0, ien_wdata = '0, ists_wdata = '0;
  logic [7:0]  sw_rx_byte, eng_tx_byte;
  logic [31:0] fifo_level, ien, ists;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_irq_unit u_dut (
    .clk(clk), .rst(rst),
    .sw_tx_push(sw_tx_push), .sw_tx_byte(sw_tx_byte),
    .sw_rx_pop(sw_rx_pop), .sw_rx_byte(sw_rx_byte),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
    .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .ists_wr(ists_wr), .ists_wdata(ists_wdata),
    .xfer_done(xfer_done),
    .fifo_level(fifo_level), .ien(ien), .ists(ists), .irq(irq)
  );

  // Op codes: 0 sw push, 1 eng pop, 2 eng push, 3 sw pop,
  // 4 control write, 5 enable write, 6 clear write, 7 done pulse.
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic [31:0] lvl;
    logic [31:0] sts;
    logic [31:0] en;
    logic        irq;
    logic [7:0]  byt;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{3'd5, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h00},
    '{3'd6, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h00},
    '{3'd0, 32'h0000_00A5, 32'h0001_0000, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h00},
    '{3'd0, 32'h0000_003C, 32'h0002_0000, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h00},
    '{3'd1, 32'h0000_0000, 32'h0001_0000, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'hA5},
    '{3'd1, 32'h0000_0000, 32'h0000_0000, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h3C},
    '{3'd1, 32'h0000_0000, 32'h0000_0000, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h3C},
    '{3'd2, 32'h0000_005A, 32'h0000_0001, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h00},
    '{3'd2, 32'h0000_00C3, 32'h0000_0002, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h00},
    '{3'd3, 32'h0000_0000, 32'h0000_0001, 32'h0000_1000, 32'h0001_1010, 1'b1, 8'h5A},
    '{3'd7, 32'h0000_0000, 32'h0000_0001, 32'h0001_1000, 32'h0001_1010, 1'b1, 8'h00},
    '{3'd5, 32'h0001_0000, 32'h0000_0001, 32'h0001_1000, 32'h0001_0000, 1'b1, 8'h00},
    '{3'd6, 32'h0001_0000, 32'h0000_0001, 32'h0000_1000, 32'h0001_0000, 1'b0, 8'h00},
    '{3'd4, 32'h0000_0200, 32'h0000_0000, 32'h0000_1000, 32'h0001_0000, 1'b0, 8'h00},
    '{3'd3, 32'h0000_0000, 32'h0000_0000, 32'h0000_1000, 32'h0001_0000, 1'b0, 8'h5A},
    '{3'd5, 32'h0000_0000, 32'h0000_0000, 32'h0000_1000, 32'h0000_0000, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    sw_tx_push = 0; sw_rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
    ctl_wr = 0; ien_wr = 0; ists_wr = 0; xfer_done = 0;
  endtask

  // Called at a falling edge; holds the strobe across one rising edge.
  task automatic drive(input int op, input logic [31:0] d);
    case (op)
      0: begin sw_tx_push = 1; sw_tx_byte = d[7:0]; end
      1: eng_tx_pop = 1;
      2: begin eng_rx_push = 1; eng_rx_byte = d[7:0]; end
      3: sw_rx_pop = 1;
      4: begin ctl_wr = 1; ctl_wdata = d; end
      5: begin ien_wr = 1; ien_wdata = d; end
      6: begin ists_wr = 1; ists_wdata = d; end
      default: xfer_done = 1;
    endcase
    @(posedge clk); @(negedge clk);
    idle_all();
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    idle_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: everything is zero while reset is held.
    chk("R12 level", fifo_level, 32'h0);
    chk("R12 pending", ists, 32'h0);
    chk("R12 enable", ien, 32'h0);
    chk("R12 irq", {31'h0, irq}, 32'h0);
    rst = 0;
    settle(); settle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    do_reset();

    // Vector table walk.
    for (int i = 0; i < 16; i++) begin
      drive(int'(TBL[i].op), TBL[i].data);
      settle();
      chk("R2 level word", fifo_level, TBL[i].lvl);
      chk("R9 pending word", ists, TBL[i].sts);
      chk("R10 enable word", ien, TBL[i].en);
      chk("R11 irq", {31'h0, irq}, {31'h0, TBL[i].irq});
      if (TBL[i].op == 3'd1) chk("R1 engine read byte", {24'h0, eng_tx_byte}, {24'h0, TBL[i].byt});
      if (TBL[i].op == 3'd3) chk("R4 software read byte", {24'h0, sw_rx_byte}, {24'h0, TBL[i].byt});
    end

    // Outbound watermark, full limit and ordering.
    do_reset();
    chk("R7 low watermark after reset", {31'h0, ists[12]}, 32'h1);
    for (int k = 0; k <= 16; k++) drive(0, k);
    settle();
    drive(6, 32'h0000_1000);
    settle();
    chk("R7 not low at 17", {31'h0, ists[12]}, 32'h0);
    drive(1, 0);
    chk("R1 first byte out", {24'h0, eng_tx_byte}, 32'h0);
    settle();
    chk("R7 low at 16", {31'h0, ists[12]}, 32'h1);
    for (int k = 17; k <= 64; k++) drive(0, k);
    settle();
    chk("R1 full level", fifo_level, 32'h0040_0000);
    drive(0, 32'hEE);
    settle();
    chk("R3 push at full dropped", fifo_level, 32'h0040_0000);
    for (int k = 1; k <= 64; k++) begin
      drive(1, 0);
      chk("R3 order intact after dropped push", {24'h0, eng_tx_byte}, k);
    end
    settle();
    chk("R4 drained level", fifo_level, 32'h0);

    // Inbound watermark, irq masking and queue emptying.
    drive(5, 32'h0000_0010);
    for (int k = 0; k < 47; k++) drive(2, k);
    settle();
    drive(6, 32'hFFFF_FFFF);
    settle();
    chk("R6 not high at 47", ists, 32'h0000_1000);
    chk("R11 masked source", {31'h0, irq}, 32'h0);
    drive(2, 8'h47);
    settle();
    chk("R6 high at 48", ists, 32'h0000_1010);
    chk("R11 enabled source", {31'h0, irq}, 32'h1);
    drive(4, 32'h0000_0100);
    settle();
    chk("R5 outbound empty leaves inbound", fifo_level, 32'h0000_0030);
    ctl_wr = 1; ctl_wdata = 32'h0000_0200; eng_rx_push = 1; eng_rx_byte = 8'h99;
    @(posedge clk); @(negedge clk);
    idle_all();
    settle();
    chk("R5 empty beats push", fifo_level, 32'h0);

    // Done bit, selective clear, clear timing.
    drive(7, 0);
    settle();
    chk("R8 done set", ists, 32'h0001_1010);
    repeat (5) @(negedge clk);
    chk("R8 done held", {31'h0, ists[16]}, 32'h1);
    drive(6, 32'h0000_0010);
    settle();
    chk("R9 zero bits untouched", ists, 32'h0001_1000);
    drive(6, 32'h0000_1000);
    chk("R9 cleared in write cycle", {31'h0, ists[12]}, 32'h0);
    settle();
    chk("R9 live source re-arms", {31'h0, ists[12]}, 32'h1);
    chk("R11 irq follows enable", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule